// File: doc/BRIEF.md
# Exception Trigger and Fetch-Phase Priority Unit

This unit is a debug trigger block that sits beside the trap logic of a simple in-order core. It watches every trap the core takes. When a trap comes from an exception whose cause code is enabled in a programmable cause mask, it latches a pending fire. Interrupt traps never latch one. The fire is not delivered when the trap happens. It is delivered on the first fetch request that follows, which is the first fetch of the handler, and that fetch is suppressed.

The same fetch slot also hosts an execute-address comparator. When the comparator matches the fetch PC, the instruction is suppressed, so it is never fetched and never makes a data access. A pending exception fire wins the slot over the address match. The address match then fires on the same PC once the core resumes. A one-shot skip flag, set together with a resume, lets the resumed instruction pass the comparator a single time.

Both kinds of fire perform one programmable action: a debug halt or a breakpoint request. While the unit is halted, every fetch is suppressed until a resume strobe arrives.

Top module: `etrg_top`

## Requirements
- R1: A trap with `trap_is_irq`=1 never latches a pending fire, even when the mask bit for its cause is set.
- R2: An exception trap with cause code c latches a pending fire exactly when bit c of the cause mask is 1. For example, bit 2 enables illegal instruction and bit 13 enables load page fault. A trap whose mask bit is 0 has no effect.
- R3: A fire is deferred. A fetch in the same cycle as the matching trap is unaffected. The first fetch request in a later cycle fires: `exc_fire`=1 and `fetch_suppress`=1, in the same cycle as that fetch.
- R4: When a fire is pending and the fetch PC also matches the enabled address comparator, only the exception fire is reported (`exc_fire`=1, `addr_fire`=0).
- R5: After the exception fire halts the unit and a resume arrives without skip, a fetch of the same PC raises `addr_fire` with suppression.
- R6: The address comparator fires only when `cmp_en`=1 and `fetch_pc` equals `cmp_addr`. A firing fetch is suppressed. While `fetch_req`=0, all request and fire outputs stay 0.
- R7: The action register selects the action of every fire. Action 0 raises `halt_req` and halts the unit. Action 1 raises `bkpt_req` and does not halt. Exactly one of the two is raised per fire.
- R8: A breakpoint trap (cause 3) re-arms the exception trigger only when mask bit 3 is set.
- R9: Delivering a fire clears the pending flag. Several matching traps that arrive before delivery produce a single fire.
- R10: While halted, every fetch request is suppressed and no fire or request is raised. A resume clears the halt in the following cycle.
- R11: A resume with `resume_skip`=1 lets the next fetch pass the address comparator once. The fetch after that is compared again.
- R12: After reset the cause mask is 0, the action is halt, no fire is pending and the unit is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the mask and action registers |
| cfg_mask | input | XLEN | New cause mask |
| cfg_action | input | 1 | New action: 0 halt, 1 breakpoint |
| trap_taken | input | 1 | Trap-taken strobe |
| trap_cause | input | CAUSE_W | Cause code of the trap |
| trap_is_irq | input | 1 | Trap is an interrupt |
| fetch_req | input | 1 | Fetch request strobe |
| fetch_pc | input | ADDR_W | PC of the requested fetch |
| cmp_en | input | 1 | Enable for the execute-address comparator |
| cmp_addr | input | ADDR_W | Address compared against the fetch PC |
| resume | input | 1 | Resume strobe, takes effect only while halted |
| resume_skip | input | 1 | With resume: skip the address comparator once |
| fetch_suppress | output | 1 | Current fetch must not proceed |
| halt_req | output | 1 | A fire requests a debug halt |
| bkpt_req | output | 1 | A fire requests a breakpoint exception |
| exc_fire | output | 1 | The exception trigger fired on this fetch |
| addr_fire | output | 1 | The address trigger fired on this fetch |

## Verification
Every fire, request and suppression output is combinational from the current fetch request and the registered state, so its result is due in the same cycle as the fetch. The bench drives inputs just after a rising edge and compares at the following falling edge. A trap, configuration write or resume changes state at the next rising edge and therefore affects only fetches in later cycles. The bench places the deferral check in the trap cycle itself and every other check at least one cycle later. The reset synchronizer adds two cycles after reset release before any stimulus is applied.

// File: rtl/etrg_pkg.sv
package etrg_pkg;
  typedef enum logic {
    ACT_HALT = 1'b0,
    ACT_BKPT = 1'b1
  } etrg_action_e;
endpackage

// File: rtl/etrg_rst_sync.sv
module etrg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/etrg_cause_match.sv
module etrg_cause_match #(
  parameter int XLEN = 32,
  localparam int CAUSE_W = $clog2(XLEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [XLEN-1:0]    cfg_mask,
  input  logic               trap_taken,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               trap_is_irq,
  input  logic               deliver,
  output logic               pending
);
  logic [XLEN-1:0] mask_q, mask_d;
  logic            pend_q, pend_d;
  logic            arm;

  // cause decode: one mask bit per exception code
  always_comb begin
    arm = trap_taken && !trap_is_irq && mask_q[trap_cause];
  end

  always_comb begin
    mask_d = mask_q;
    if (cfg_we) mask_d = cfg_mask;
  end

  // a fresh match overrides a same-cycle delivery; repeats collapse
  always_comb begin
    pend_d = pend_q;
    if (arm)          pend_d = 1'b1;
    else if (deliver) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

  AST_IRQ_NEVER_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && trap_is_irq && !pend_q) |=> !pend_q); // R1
  AST_MASKED_CAUSE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && !trap_is_irq && mask_q[trap_cause]) |=> pend_q); // R2
  AST_DELIVERY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && !trap_taken) |=> !pend_q); // R9
endmodule

// File: rtl/etrg_addr_cmp.sv
module etrg_addr_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              cmp_en,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic              running,
  input  logic              resume,
  input  logic              resume_skip,
  output logic              addr_match
);
  logic skip_q, skip_d;
  logic hit;
  logic arm_skip;

  always_comb begin
    hit        = cmp_en && (fetch_pc == cmp_addr);
    addr_match = hit && !skip_q;
    arm_skip   = resume && !running && resume_skip;
  end

  // the skip flag covers exactly one fetch while running
  always_comb begin
    skip_d = skip_q;
    if (arm_skip)                  skip_d = 1'b1;
    else if (fetch_req && running) skip_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip_q <= 1'b0;
    else        skip_q <= skip_d;
  end

  AST_SKIP_IS_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && fetch_req && running) |=> !skip_q); // R11
  AST_SKIP_ARMED_BY_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !running && resume_skip) |=> skip_q); // R11
endmodule

// File: rtl/etrg_arbiter.sv
module etrg_arbiter
  import etrg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_action,
  input  logic fetch_req,
  input  logic pending,
  input  logic addr_match,
  input  logic resume,
  output logic running,
  output logic deliver,
  output logic fetch_suppress,
  output logic halt_req,
  output logic bkpt_req,
  output logic exc_fire,
  output logic addr_fire
);
  etrg_action_e act_q, act_d;
  logic         halted_q, halted_d;
  logic         any_fire;

  // slot priority: leftover exception fire, then fetch-phase address match
  always_comb begin
    running        = !halted_q;
    exc_fire       = fetch_req && running && pending;
    addr_fire      = fetch_req && running && !pending && addr_match;
    any_fire       = exc_fire || addr_fire;
    halt_req       = any_fire && (act_q == ACT_HALT);
    bkpt_req       = any_fire && (act_q == ACT_BKPT);
    fetch_suppress = fetch_req && (halted_q || any_fire);
    deliver        = exc_fire;
  end

  always_comb begin
    act_d = act_q;
    if (cfg_we) act_d = etrg_action_e'(cfg_action);
  end

  always_comb begin
    halted_d = halted_q;
    if (halt_req)    halted_d = 1'b1;
    else if (resume) halted_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= ACT_HALT;
      halted_q <= 1'b0;
    end else begin
      act_q    <= act_d;
      halted_q <= halted_d;
    end
  end

  AST_PENDING_WINS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !halted_q && pending) |-> (exc_fire && !addr_fire)); // R4
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, bkpt_req})); // R7
  AST_HALTED_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && fetch_req) |-> (fetch_suppress && !halt_req && !bkpt_req)); // R10
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !resume) |=> halted_q); // R10
  AST_QUIET_WITHOUT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |-> !(halt_req || bkpt_req || exc_fire || addr_fire || fetch_suppress)); // R6
endmodule

// File: rtl/etrg_top.sv
module etrg_top #(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 32,
  localparam int CAUSE_W = $clog2(XLEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [XLEN-1:0]    cfg_mask,
  input  logic               cfg_action,
  input  logic               trap_taken,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               trap_is_irq,
  input  logic               fetch_req,
  input  logic [ADDR_W-1:0]  fetch_pc,
  input  logic               cmp_en,
  input  logic [ADDR_W-1:0]  cmp_addr,
  input  logic               resume,
  input  logic               resume_skip,
  output logic               fetch_suppress,
  output logic               halt_req,
  output logic               bkpt_req,
  output logic               exc_fire,
  output logic               addr_fire
);
  logic rst_sync_n;
  logic pending;
  logic deliver;
  logic running;
  logic addr_match;

  etrg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  etrg_cause_match #(.XLEN(XLEN)) u_match (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_we      (cfg_we),
    .cfg_mask    (cfg_mask),
    .trap_taken  (trap_taken),
    .trap_cause  (trap_cause),
    .trap_is_irq (trap_is_irq),
    .deliver     (deliver),
    .pending     (pending)
  );

  etrg_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fetch_req   (fetch_req),
    .fetch_pc    (fetch_pc),
    .cmp_en      (cmp_en),
    .cmp_addr    (cmp_addr),
    .running     (running),
    .resume      (resume),
    .resume_skip (resume_skip),
    .addr_match  (addr_match)
  );

  etrg_arbiter u_arb (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .cfg_we         (cfg_we),
    .cfg_action     (cfg_action),
    .fetch_req      (fetch_req),
    .pending        (pending),
    .addr_match     (addr_match),
    .resume         (resume),
    .running        (running),
    .deliver        (deliver),
    .fetch_suppress (fetch_suppress),
    .halt_req       (halt_req),
    .bkpt_req       (bkpt_req),
    .exc_fire       (exc_fire),
    .addr_fire      (addr_fire)
  );
endmodule

// File: tb/test_etrg_top.sv
module test_etrg_top;
  localparam int XLEN = 32;
  localparam int ADDR_W = 32;
  localparam int CAUSE_W = $clog2(XLEN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we, cfg_action, trap_taken, trap_is_irq, fetch_req, cmp_en, resume, resume_skip;
  logic [XLEN-1:0] cfg_mask;
  logic [CAUSE_W-1:0] trap_cause;
  logic [ADDR_W-1:0] fetch_pc, cmp_addr;
  logic fetch_suppress, halt_req, bkpt_req, exc_fire, addr_fire;

  typedef struct {
    logic [4:0] v;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  etrg_top #(.XLEN(XLEN), .ADDR_W(ADDR_W)) i_etrg_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_action(cfg_action),
    .trap_taken(trap_taken), .trap_cause(trap_cause), .trap_is_irq(trap_is_irq),
    .fetch_req(fetch_req), .fetch_pc(fetch_pc), .cmp_en(cmp_en), .cmp_addr(cmp_addr),
    .resume(resume), .resume_skip(resume_skip), .fetch_suppress(fetch_suppress),
    .halt_req(halt_req), .bkpt_req(bkpt_req), .exc_fire(exc_fire), .addr_fire(addr_fire)
  );

  // output vector order: {suppress, halt, bkpt, exc, addr}
  localparam logic [4:0] NONE = 5'b00000;
  localparam logic [4:0] EXC_H = 5'b11010;
  localparam logic [4:0] ADR_H = 5'b11001;
  localparam logic [4:0] EXC_B = 5'b10110;
  localparam logic [4:0] ADR_B = 5'b10101;
  localparam logic [4:0] SUPP = 5'b10000;

  task automatic clr_in();
    cfg_we = 0; cfg_mask = '0; cfg_action = 0; trap_taken = 0; trap_cause = '0;
    trap_is_irq = 0; fetch_req = 0; fetch_pc = '0; resume = 0; resume_skip = 0;
  endtask

  task automatic slot();
    @(posedge clk); #2; clr_in();
  endtask

  task automatic cfg(input logic [XLEN-1:0] m, input logic a);
    slot(); cfg_we = 1; cfg_mask = m; cfg_action = a;
  endtask

  task automatic trap(input int c, input logic irq);
    slot(); trap_taken = 1; trap_cause = CAUSE_W'(c); trap_is_irq = irq;
  endtask

  task automatic fetch(input logic [ADDR_W-1:0] pc, input logic [4:0] e, input string r);
    exp_t it;
    slot(); fetch_req = 1; fetch_pc = pc;
    it.v = e; it.req = r; sb_q.push_back(it);
  endtask

  task automatic fetch_with_trap(input logic [ADDR_W-1:0] pc, input int c,
                                 input logic [4:0] e, input string r);
    exp_t it;
    slot(); fetch_req = 1; fetch_pc = pc; trap_taken = 1; trap_cause = CAUSE_W'(c);
    it.v = e; it.req = r; sb_q.push_back(it);
  endtask

  task automatic do_resume(input logic sk);
    slot(); resume = 1; resume_skip = sk;
  endtask

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [4:0] got;
      got = {fetch_suppress, halt_req, bkpt_req, exc_fire, addr_fire};
      if (fetch_req) begin
        checks++;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard empty: actual=%b expected=<none>", got);
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          if (got !== it.v) begin
            errors++;
            $display("FAIL %s pc=%h: actual=%b expected=%b", it.req, fetch_pc, got, it.v);
          end
        end
      end else begin
        checks++;
        if (got !== NONE) begin
          errors++;
          $display("FAIL R6 idle outputs: actual=%b expected=%b", got, NONE);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    clr_in(); cmp_en = 0; cmp_addr = 32'h400;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    // R12: nothing pending, running, mask empty
    fetch(32'h010, NONE, "R12");
    trap(13, 0);
    fetch(32'h014, NONE, "R12");
    cfg((32'h1 << 13) | (32'h1 << 2), 1'b0);
    // R1: interrupt trap with mask bit set
    trap(13, 1);
    fetch(32'h100, NONE, "R1");
    // R2: unset cause
    trap(5, 0);
    fetch(32'h104, NONE, "R2");
    // R3: deferral, then fire on the next fetch
    fetch_with_trap(32'h200, 13, NONE, "R3");
    fetch(32'h300, EXC_H, "R3");
    // R10: halted
    fetch(32'h300, SUPP, "R10");
    do_resume(0);
    // R9: pending cleared by delivery
    fetch(32'h300, NONE, "R9");
    // R4/R5: priority and sequence on the handler entry
    cmp_en = 1;
    trap(2, 0);
    fetch(32'h400, EXC_H, "R4");
    do_resume(0);
    fetch(32'h400, ADR_H, "R5");
    // R11: skip once, then compared again
    do_resume(1);
    fetch(32'h400, NONE, "R11");
    fetch(32'h400, ADR_H, "R11");
    do_resume(0);
    // R9: repeated matching traps collapse into one fire
    trap(13, 0);
    trap(2, 0);
    fetch(32'h500, EXC_H, "R9");
    do_resume(0);
    fetch(32'h500, NONE, "R9");
    // R7: breakpoint action does not halt
    cfg((32'h1 << 13) | (32'h1 << 2), 1'b1);
    trap(13, 0);
    fetch(32'h600, EXC_B, "R7");
    fetch(32'h604, NONE, "R7");
    fetch(32'h400, ADR_B, "R7");
    // R8: breakpoint cause re-arms only with mask bit 3
    trap(3, 0);
    fetch(32'h700, NONE, "R8");
    cfg((32'h1 << 13) | (32'h1 << 2) | (32'h1 << 3), 1'b1);
    trap(3, 0);
    fetch(32'h700, EXC_B, "R8");
    // R6: comparator disabled
    cmp_en = 0;
    fetch(32'h400, NONE, "R6");
    slot();
    slot();
    if (sb_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard leftover: actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end
endmodule